// File: doc/BRIEF.md
# Spare-Lane Routing and Drive Configuration Controller

This block sits beside a twelve-lane parallel optical link and decides which physical lane carries each of the eight logical channels. Physical lanes 2 through 9 are the primary lanes. Lanes 0, 1, 10 and 11 are spares that can take over a channel whose primary lane has failed. The block contains the single-bit crossbar that places channel data on lanes. It also holds one 8-bit modulation-drive code per physical lane and presents it on the lane's drive output.

Settings arrive as 16-bit command frames. Bits [15:12] carry the opcode, bits [11:8] the index and bits [7:0] the data. The block can return to a safe state without a command. Reset or a silent command link restores the straight mapping and the nominal drive code. Every configuration register is held as three voted copies, and the copies are rewritten from the vote on every cycle.

Top module: `lane_route_ctrl`

## Requirements
- R1: After a synchronous active-low reset, logical channel c sits on physical lane c+2, so `chan_lane` reads 32'h98765432 with channel c in bits [4c+3:4c]. Lanes 2..9 then drive code 100 (DEFAULT_MOD_CODE), and lanes 0, 1, 10 and 11 drive 0.
- R2: `lane_data[p]` equals `chan_data[c]` for the channel c that is mapped to lane p, and is 0 when no channel is mapped to lane p. The path is combinational.
- R3: An opcode-1 frame with index p < 12 stores data as the drive code of lane p. The new code appears on `lane_drive[8p+7:8p]` from the next clock cycle, provided lane p is in use.
- R4: An opcode-2 frame with channel index c < 8 and data t < 12 moves channel c to physical lane t from the next cycle, unless R6 rejects it.
- R5: A frame is rejected, and changes no state, when it is opcode 1 with index > 11, or opcode 2 with index > 7 or data > 11.
- R6: An opcode-2 frame is rejected when its target lane is already used by a different channel, so no two channels ever share a lane.
- R7: An opcode-15 frame restores the R1 map and sets every drive code to 100 in the next cycle.
- R8: A watchdog counts the cycles since the last accepted frame. When the count reaches a non-zero `timeout_limit`, the R7 defaults are applied in the following cycle. A limit of 0 disables the watchdog.
- R9: A lane with no channel mapped to it drives code 0. Its stored code is kept, and it reappears when a channel is routed back onto that lane.
- R10: Frames with any opcode other than 1, 2 or 15 are ignored and do not restart the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command frame present this cycle |
| cmd_frame | input | 16 | {opcode[3:0], index[3:0], data[7:0]} |
| timeout_limit | input | 16 | Watchdog limit in cycles; 0 disables |
| chan_data | input | 8 | Logical channel data bits |
| lane_data | output | 12 | Data placed on each physical lane |
| lane_drive | output | 96 | Drive code per physical lane, lane p in bits [8p+7:8p] |
| chan_lane | output | 32 | Physical lane selected per logical channel |

## Verification
The assertions assume the following about the inputs:
- `cmd_frame` is a known value whenever `cmd_valid` is high.
- Reset is applied before the first frame.

A rejected or unknown frame could coincide with a watchdog expiry. For that reason, the stability checks on such frames also accept a return to the defaults. The stimulus avoids this overlap by holding `timeout_limit` at 0 everywhere except the watchdog test. It also drives frames only while `cmd_valid` is high, on the falling edge, with a known frame word.

// File: rtl/lane_route_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes, opcode encoding and map helpers for the lane
// routing controller. Assumes fewer than 16 physical lanes.
package lane_route_pkg;
    localparam int NUM_LANES = 12;
    localparam int NUM_CH    = 8;
    localparam int SPARE_LO  = 2;
    localparam int LANE_W    = 4;
    localparam int CODE_W    = 8;
    localparam int IDX_W     = 4;
    localparam int OP_W      = 4;
    localparam int FRAME_W   = OP_W + IDX_W + CODE_W;
    localparam int MAP_W     = NUM_CH * LANE_W;
    localparam int DRV_W     = NUM_LANES * CODE_W;

    typedef logic [MAP_W-1:0] map_t;

    typedef enum logic [OP_W-1:0] {
        OP_SET_DRIVE = 4'd1,
        OP_SET_ROUTE = 4'd2,
        OP_RESTORE   = 4'd15
    } opcode_e;

    // Lane selected for channel c within a packed map.
    function automatic logic [LANE_W-1:0] chan_of(map_t m, int c);
        return m[c*LANE_W +: LANE_W];
    endfunction

    // True when any channel of the map sits on lane p.
    function automatic logic lane_used(map_t m, int p);
        logic hit;
        hit = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (m[c*LANE_W +: LANE_W] == LANE_W'(p)) hit = 1'b1;
        end
        return hit;
    endfunction

    // Straight map: channel c on lane c + SPARE_LO.
    function automatic map_t default_map();
        map_t m;
        for (int c = 0; c < NUM_CH; c++) m[c*LANE_W +: LANE_W] = LANE_W'(c + SPARE_LO);
        return m;
    endfunction
endpackage

// File: rtl/cfg_tmr_reg.sv
`timescale 1ns/1ps
// cfg_tmr_reg: configuration register kept as three copies with a bitwise
// majority vote. Without a load, every copy is refreshed from the vote, so
// a disagreeing copy is repaired on the next cycle.
// Assumes at most one copy is upset between two clock edges.
module cfg_tmr_reg #(
    parameter int            W         = 8,
    parameter logic [W-1:0]  RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    logic [W-1:0] copy_a, copy_b, copy_c;
    logic [W-1:0] next_val;

    // Majority vote across the three copies.
    always_comb q = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);

    // Value written back into all copies: new data or the scrubbed vote.
    always_comb next_val = load ? load_val : q;

    // Copy storage with synchronous reset to the default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_a <= RESET_VAL;
            copy_b <= RESET_VAL;
            copy_c <= RESET_VAL;
        end else begin
            copy_a <= next_val;
            copy_b <= next_val;
            copy_c <= next_val;
        end
    end
endmodule

// File: rtl/lane_cmd_decode.sv
`timescale 1ns/1ps
// lane_cmd_decode: checks a command frame against the current map and turns
// it into per-lane and per-channel write strobes. Frames that are out of
// range, would collide with another channel's lane, or carry an unknown
// opcode produce no strobe and are not reported as accepted.
// Assumes cmd_frame is stable while cmd_valid is high.
module lane_cmd_decode
    import lane_route_pkg::*;
(
    input  logic                 cmd_valid,
    input  logic [FRAME_W-1:0]   cmd_frame,
    input  map_t                 cur_map,
    output logic [NUM_LANES-1:0] drive_we,
    output logic [NUM_CH-1:0]    route_we,
    output logic [CODE_W-1:0]    wr_data,
    output logic                 restore,
    output logic                 accepted
);
    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] idx;
    logic             collide;
    logic             idx_lane_ok;
    logic             idx_ch_ok;
    logic             tgt_ok;

    // Split the frame into its fields.
    always_comb begin
        op      = cmd_frame[FRAME_W-1 -: OP_W];
        idx     = cmd_frame[CODE_W +: IDX_W];
        wr_data = cmd_frame[CODE_W-1:0];
    end

    // Range checks and detection of a target lane held by another channel.
    always_comb begin
        idx_lane_ok = idx < IDX_W'(NUM_LANES);
        idx_ch_ok   = idx < IDX_W'(NUM_CH);
        tgt_ok      = wr_data < CODE_W'(NUM_LANES);
        collide     = 1'b0;
        for (int j = 0; j < NUM_CH; j++) begin
            if ((IDX_W'(j) != idx) && (cur_map[j*LANE_W +: LANE_W] == wr_data[LANE_W-1:0]))
                collide = 1'b1;
        end
    end

    // Strobe generation per opcode.
    always_comb begin
        drive_we = '0;
        route_we = '0;
        restore  = 1'b0;
        accepted = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_SET_DRIVE: begin
                    if (idx_lane_ok) begin
                        accepted = 1'b1;
                        for (int p = 0; p < NUM_LANES; p++)
                            drive_we[p] = (idx == IDX_W'(p));
                    end
                end
                OP_SET_ROUTE: begin
                    if (idx_ch_ok && tgt_ok && !collide) begin
                        accepted = 1'b1;
                        for (int c = 0; c < NUM_CH; c++)
                            route_we[c] = (idx == IDX_W'(c));
                    end
                end
                OP_RESTORE: begin
                    accepted = 1'b1;
                    restore  = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/comm_watchdog.sv
`timescale 1ns/1ps
// comm_watchdog: counts cycles since the last accepted frame and raises
// expire for one cycle when the count reaches a non-zero limit. A kick in
// the same cycle wins over expiry. A limit of 0 turns the watchdog off.
module comm_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Expiry decision against the programmed limit.
    always_comb expire = !kick && (limit != '0) && (cnt >= limit);

    // Saturating silence counter, cleared on kick or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (kick || expire)  cnt <= '0;
        else if (cnt != '1)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lane_crossbar.sv
`timescale 1ns/1ps
// lane_crossbar: places each channel's bit on the lane its map entry
// selects, and gates each lane's drive code to zero when no channel uses
// that lane. Assumes the map has no two channels on one lane.
module lane_crossbar
    import lane_route_pkg::*;
(
    input  map_t                 map_in,
    input  logic [NUM_CH-1:0]    chan_data,
    input  logic [DRV_W-1:0]     code_in,
    output logic [NUM_LANES-1:0] lane_data,
    output logic [DRV_W-1:0]     lane_drive
);
    logic [NUM_LANES-1:0] used;

    // Per-lane selection of channel data and occupancy.
    always_comb begin
        lane_data = '0;
        used      = '0;
        for (int p = 0; p < NUM_LANES; p++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (map_in[c*LANE_W +: LANE_W] == LANE_W'(p)) begin
                    lane_data[p] = chan_data[c];
                    used[p]      = 1'b1;
                end
            end
        end
    end

    // Drive gating: idle lanes stay dark.
    generate
        for (genvar gp = 0; gp < NUM_LANES; gp++) begin : g_gate
            assign lane_drive[gp*CODE_W +: CODE_W] =
                used[gp] ? code_in[gp*CODE_W +: CODE_W] : '0;
        end
    endgenerate
endmodule

// File: rtl/lane_route_ctrl.sv
`timescale 1ns/1ps
// lane_route_ctrl: top of the spare-lane routing controller. It decodes
// command frames, holds the channel map and lane drive codes in voted
// registers, restores defaults on reset, restore command or watchdog
// expiry, and drives the lane crossbar.
// Assumes a synchronous active-low reset is applied at power-up.
module lane_route_ctrl
    import lane_route_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEFAULT_MOD_CODE = 8'd100,
    parameter int                TIMEOUT_W        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [FRAME_W-1:0]   cmd_frame,
    input  logic [TIMEOUT_W-1:0] timeout_limit,
    input  logic [NUM_CH-1:0]    chan_data,
    output logic [NUM_LANES-1:0] lane_data,
    output logic [DRV_W-1:0]     lane_drive,
    output logic [MAP_W-1:0]     chan_lane
);
    logic [NUM_LANES-1:0] drive_we;
    logic [NUM_CH-1:0]    route_we;
    logic [CODE_W-1:0]    wr_data;
    logic                 restore;
    logic                 accepted;
    logic                 expire;
    logic                 apply_def;
    map_t                 map_q;
    logic [DRV_W-1:0]     code_q;

    lane_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_frame (cmd_frame),
        .cur_map   (map_q),
        .drive_we  (drive_we),
        .route_we  (route_we),
        .wr_data   (wr_data),
        .restore   (restore),
        .accepted  (accepted)
    );

    comm_watchdog #(.CNT_W(TIMEOUT_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (accepted),
        .limit  (timeout_limit),
        .expire (expire)
    );

    // Either a restore frame or watchdog expiry reapplies the defaults.
    always_comb apply_def = restore || expire;

    // One voted drive-code register per physical lane.
    generate
        for (genvar gp = 0; gp < NUM_LANES; gp++) begin : g_code
            cfg_tmr_reg #(.W(CODE_W), .RESET_VAL(DEFAULT_MOD_CODE)) u_code (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (apply_def || drive_we[gp]),
                .load_val (apply_def ? DEFAULT_MOD_CODE : wr_data),
                .q        (code_q[gp*CODE_W +: CODE_W])
            );
        end
    endgenerate

    // One voted lane-select register per logical channel.
    generate
        for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_map
            localparam logic [LANE_W-1:0] HOME = LANE_W'(gc + SPARE_LO);
            cfg_tmr_reg #(.W(LANE_W), .RESET_VAL(HOME)) u_sel (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (apply_def || route_we[gc]),
                .load_val (apply_def ? HOME : wr_data[LANE_W-1:0]),
                .q        (map_q[gc*LANE_W +: LANE_W])
            );
        end
    endgenerate

    lane_crossbar u_xbar (
        .map_in     (map_q),
        .chan_data  (chan_data),
        .code_in    (code_q),
        .lane_data  (lane_data),
        .lane_drive (lane_drive)
    );

    // Map output for the analog select inputs.
    always_comb chan_lane = map_q;
endmodule

// File: rtl/lane_route_checker.sv
`timescale 1ns/1ps
// lane_route_checker: port-level properties of lane_route_ctrl, bound to it.
// The watchdog timing (R8) is left to the bench, because its window is a
// run-time limit.
module lane_route_checker
    import lane_route_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEFAULT_MOD_CODE = 8'd100
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [FRAME_W-1:0]   cmd_frame,
    input logic [NUM_CH-1:0]    chan_data,
    input logic [NUM_LANES-1:0] lane_data,
    input logic [DRV_W-1:0]     lane_drive,
    input logic [MAP_W-1:0]     chan_lane
);
    logic [OP_W-1:0]   op;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] dat;
    logic              uniq_ok, idle_ok, xbar_ok, hit, clash;
    logic              good_route, bad_index, unknown_op, at_default;
    logic [DRV_W-1:0]  def_drive;

    function automatic logic [CODE_W-1:0] drive_of(logic [DRV_W-1:0] v, logic [IDX_W-1:0] p);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_LANES; k++) if (p == IDX_W'(k)) r = v[k*CODE_W +: CODE_W];
        return r;
    endfunction

    always_comb begin
        op  = cmd_frame[FRAME_W-1 -: OP_W];
        idx = cmd_frame[CODE_W +: IDX_W];
        dat = cmd_frame[CODE_W-1:0];
        uniq_ok = 1'b1;
        for (int a = 0; a < NUM_CH; a++)
            for (int b = a + 1; b < NUM_CH; b++)
                if (chan_of(chan_lane, a) == chan_of(chan_lane, b)) uniq_ok = 1'b0;
        idle_ok = 1'b1;
        for (int p = 0; p < NUM_LANES; p++)
            if (!lane_used(chan_lane, p) && (lane_drive[p*CODE_W +: CODE_W] != '0 || lane_data[p]))
                idle_ok = 1'b0;
        xbar_ok = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            hit = 1'b0;
            for (int p = 0; p < NUM_LANES; p++)
                if (chan_of(chan_lane, c) == LANE_W'(p) && lane_data[p] == chan_data[c]) hit = 1'b1;
            if (!hit) xbar_ok = 1'b0;
        end
        clash = 1'b0;
        for (int j = 0; j < NUM_CH; j++)
            if (IDX_W'(j) != idx && chan_of(chan_lane, j) == dat[LANE_W-1:0]) clash = 1'b1;
        good_route = cmd_valid && op == 4'd2 && idx < IDX_W'(NUM_CH) && dat < CODE_W'(NUM_LANES) && !clash;
        bad_index  = cmd_valid && ((op == 4'd1 && idx >= IDX_W'(NUM_LANES)) ||
                     (op == 4'd2 && (idx >= IDX_W'(NUM_CH) || dat >= CODE_W'(NUM_LANES))));
        unknown_op = cmd_valid && op != 4'd1 && op != 4'd2 && op != 4'd15;
        for (int p = 0; p < NUM_LANES; p++)
            def_drive[p*CODE_W +: CODE_W] = (p >= SPARE_LO && p < SPARE_LO + NUM_CH) ? DEFAULT_MOD_CODE : '0;
        at_default = (chan_lane == default_map()) && (lane_drive == def_drive);
    end

    assert_reset_defaults_R1: assert property (@(posedge clk) !rst_n |=> at_default);

    assert_xbar_follow_R2: assert property (@(posedge clk) disable iff (!rst_n) xbar_ok);

    assert_drive_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 4'd1 && idx < IDX_W'(NUM_LANES) && lane_used(chan_lane, int'(idx)))
        |=> drive_of(lane_drive, $past(idx)) == $past(dat));

    assert_route_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        good_route |=> chan_of(chan_lane, int'($past(idx))) == $past(dat[LANE_W-1:0]));

    assert_bad_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_index |=> ($stable(chan_lane) && $stable(lane_drive)) || at_default);

    assert_unique_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n) uniq_ok);

    assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 4'd15) |=> at_default);

    assert_idle_dark_R9: assert property (@(posedge clk) disable iff (!rst_n) idle_ok);

    assert_unknown_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unknown_op |=> ($stable(chan_lane) && $stable(lane_drive)) || at_default);
endmodule

bind lane_route_ctrl lane_route_checker #(.DEFAULT_MOD_CODE(DEFAULT_MOD_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_frame  (cmd_frame),
    .chan_data  (chan_data),
    .lane_data  (lane_data),
    .lane_drive (lane_drive),
    .chan_lane  (chan_lane)
);

// File: tb/lane_route_ctrl_tb.sv
`timescale 1ns/1ps
module lane_route_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_frame = '0;
    logic [15:0] timeout_limit = '0;
    logic [7:0]  chan_data = '0;
    logic [11:0] lane_data;
    logic [95:0] lane_drive;
    logic [31:0] chan_lane;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [31:0] HOME_MAP = 32'h98765432;

    always #4 clk = ~clk;

    lane_route_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_frame     (cmd_frame),
        .timeout_limit (timeout_limit),
        .chan_data     (chan_data),
        .lane_data     (lane_data),
        .lane_drive    (lane_drive),
        .chan_lane     (chan_lane)
    );

    typedef struct packed {
        logic        vld;
        logic [15:0] frame;
        logic [7:0]  din;
        logic [3:0]  probe;
        logic [7:0]  exp_drv;
        logic [11:0] exp_out;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h1437, 8'hFF, 4'd4,  8'd55,  12'h3FC}, // R3 set lane 4 code
        '{1'b1, 16'h2300, 8'h08, 4'd0,  8'd100, 12'h001}, // R4 ch3 to spare 0
        '{1'b1, 16'h1511, 8'hF7, 4'd5,  8'd0,   12'h3DC}, // R9 idle lane 5 dark
        '{1'b1, 16'h2600, 8'h40, 4'd8,  8'd100, 12'h100}, // R6 collision rejected
        '{1'b1, 16'h1C05, 8'h01, 4'd2,  8'd100, 12'h004}, // R5 lane index 12
        '{1'b1, 16'h2305, 8'h08, 4'd5,  8'd17,  12'h020}, // R9 stored code returns
        '{1'b1, 16'h2801, 8'h80, 4'd1,  8'd0,   12'h200}, // R5 channel index 8
        '{1'b1, 16'h200C, 8'h01, 4'd2,  8'd100, 12'h004}, // R5 target lane 12
        '{1'b1, 16'h7203, 8'h00, 4'd2,  8'd100, 12'h000}, // R10 unknown opcode
        '{1'b1, 16'h270B, 8'h80, 4'd11, 8'd100, 12'h800}, // R4 ch7 to spare 11
        '{1'b1, 16'h1BFF, 8'h80, 4'd11, 8'd255, 12'h800}, // R3 code on spare
        '{1'b1, 16'hF000, 8'hFF, 4'd5,  8'd100, 12'h3FC}, // R7 restore
        '{1'b0, 16'h0000, 8'h80, 4'd11, 8'd0,   12'h200}, // R7 spare dark again
        '{1'b0, 16'h0000, 8'h00, 4'd4,  8'd100, 12'h000}  // R7 code 4 restored
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 10:       return "R3";
            1, 9:        return "R4";
            2, 5:        return "R9";
            3:           return "R6";
            4, 6, 7:     return "R5";
            8:           return "R10";
            default:     return "R7";
        endcase
    endfunction

    function automatic logic [95:0] home_drive();
        logic [95:0] v;
        for (int p = 0; p < 12; p++) v[p*8 +: 8] = (p >= 2 && p <= 9) ? 8'd100 : 8'd0;
        return v;
    endfunction

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] f);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_frame = f;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        // Reset state (R1)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 map", 96'(chan_lane), 96'(HOME_MAP));
        check("R1 drive", lane_drive, home_drive());
        chan_data = 8'hA5;
        #1;
        check("R2 straight", 96'(lane_data), 96'(12'h294));

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cmd_valid = VECS[i].vld;
            cmd_frame = VECS[i].frame;
            chan_data = VECS[i].din;
            @(negedge clk);
            cmd_valid = 1'b0;
            check({vec_tag(i), " drive"}, 96'(lane_drive[VECS[i].probe*8 +: 8]), 96'(VECS[i].exp_drv));
            check("R2 lanes", 96'(lane_data), 96'(VECS[i].exp_out));
        end
        check("R7 map", 96'(chan_lane), 96'(HOME_MAP));

        // Unknown opcode leaves the map alone (R10)
        send(16'h3205);
        check("R10 map", 96'(chan_lane), 96'(HOME_MAP));

        // Watchdog expiry (R8)
        @(negedge clk);
        timeout_limit = 16'd20;
        cmd_valid = 1'b1;
        cmd_frame = 16'h1207;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (13) @(negedge clk);
        check("R8 before", 96'(lane_drive[2*8 +: 8]), 96'(8'd7));
        repeat (10) @(negedge clk);
        check("R8 after", 96'(lane_drive[2*8 +: 8]), 96'(8'd100));
        @(negedge clk);
        timeout_limit = 16'd0;

        // Limit 0 disables the watchdog (R8)
        send(16'h1309);
        repeat (300) @(negedge clk);
        check("R8 disabled", 96'(lane_drive[3*8 +: 8]), 96'(8'd9));

        // Reset in mid-run restores defaults (R1)
        send(16'h210A);
        check("R4 ch1 lane10", 96'(chan_lane[4 +: 4]), 96'(4'd10));
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 map after reset", 96'(chan_lane), 96'(HOME_MAP));
        check("R1 drive after reset", lane_drive, home_drive());

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule